// File: doc/BRIEF.md
# Receive Character FIFO

This block buffers characters between a serial receiver and the host. Each character from the receiver arrives with a one-cycle push strobe. It is stored together with three status bits that mark a stop-bit failure, a parity mismatch and a line-break detection. The host reads the oldest entry combinationally. It removes that entry with a one-cycle pop strobe and sees the three status bits in the same read.

The block keeps an occupancy count. From that count it drives a data-available flag and an interrupt request. The interrupt compares the count against one of four fixed thresholds: 1, 4, 8 or 14 entries. A character that arrives while all 16 entries are taken, with no pop in the same cycle, is dropped. The block then raises a sticky overrun flag, which stays set until the host clears it.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset `level_o` is 0 and `data_avail_o`, `irq_o` and `overrun_o` are 0.
- R2: Entries leave in arrival order. While `data_avail_o` is 1, `rd_data_o` shows the oldest stored byte.
- R3: The frame, parity and break bits pushed with a byte appear on `rd_frame_err_o`, `rd_parity_err_o` and `rd_break_o` whenever that byte is at the head.
- R4: `data_avail_o` is 1 exactly when `level_o` is at least 1.
- R5: An accepted push adds one to `level_o` at the next edge. A pop on a non-empty FIFO subtracts one. Both together leave it unchanged. A pop on an empty FIFO has no effect.
- R6: `irq_o` is 1 exactly when `level_o` is at least the threshold chosen by `trig_sel_i`: code 0 = 1, code 1 = 4, code 2 = 8, code 3 = 14. The request drops in the same cycle that the level falls below the threshold.
- R7: A push when `level_o` is 16 and no pop is made drops the character. The stored contents and level stay unchanged, and `overrun_o` is 1 from the next edge.
- R8: `overrun_o` stays set until a cycle with `ovr_clr_i` high. If a new overrun occurs in the clearing cycle, the flag stays set.
- R9: A push together with a pop at level 16 is accepted without overrun. The level stays at 16 and the new byte is placed at the tail.
- R10: `level_o` never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Receiver character strobe |
| push_data_i | input | 8 | Received byte |
| push_frame_err_i | input | 1 | Stop-bit failure for this byte |
| push_parity_err_i | input | 1 | Parity mismatch for this byte |
| push_break_i | input | 1 | Break detected for this byte |
| pop_i | input | 1 | Host removes head entry |
| trig_sel_i | input | 2 | Interrupt threshold code |
| ovr_clr_i | input | 1 | Clear overrun flag |
| rd_data_o | output | 8 | Head byte |
| rd_frame_err_o | output | 1 | Head frame bit |
| rd_parity_err_o | output | 1 | Head parity bit |
| rd_break_o | output | 1 | Head break bit |
| data_avail_o | output | 1 | At least one entry stored |
| level_o | output | 5 | Occupancy |
| irq_o | output | 1 | Level at or above threshold |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A wrong pointer or count shows at the ports one edge after the faulty update. When that happens, `level_o` or the head byte differs from the reference queue, and the bench compares both after every cycle. A write to the wrong slot can stay hidden until that entry reaches the head, which may be up to 16 pops later. Long random runs that drain the FIFO fully expose these faults. A bad overrun decision at the full boundary shows in the next cycle, either as a set flag or as a changed level or head.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  typedef struct packed {
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_sel_e;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  rx_entry_t wr_entry_i,
  input  logic      rd_en_i,
  output rx_entry_t rd_entry_o
);
  localparam int AW = $clog2(DEPTH);

  rx_entry_t      mem_q [DEPTH];
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en_i) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_entry_i;
  end

  assign rd_entry_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/rx_fifo_level.sv
module rx_fifo_level
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic [1:0]    trig_sel_i,
  output logic [CW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [CW-1:0] cnt_q, thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (inc_i && !dec_i)  cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)  cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    unique case (trig_sel_e'(trig_sel_i))
      TRIG_1:  thr = CW'(1);
      TRIG_4:  thr = CW'(4);
      TRIG_8:  thr = CW'(8);
      default: thr = CW'(14);
    endcase
  end

  assign level_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_LVL);
  assign irq_o   = (cnt_q >= thr);
endmodule

// File: rtl/rx_fifo_ovr.sv
module rx_fifo_ovr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [7:0]    push_data_i,
  input  logic          push_frame_err_i,
  input  logic          push_parity_err_i,
  input  logic          push_break_i,
  input  logic          pop_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          ovr_clr_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_frame_err_o,
  output logic          rd_parity_err_o,
  output logic          rd_break_o,
  output logic          data_avail_o,
  output logic [CW-1:0] level_o,
  output logic          irq_o,
  output logic          overrun_o
);
  logic      empty, full, rd_en, wr_en, ovr_set;
  rx_entry_t wr_entry, rd_entry;

  assign rd_en   = pop_i && !empty;
  assign wr_en   = push_i && (!full || rd_en);
  assign ovr_set = push_i && full && !rd_en;

  assign wr_entry = '{brk: push_break_i, par: push_parity_err_i,
                      frm: push_frame_err_i, data: push_data_i};

  rx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_entry_i(wr_entry),
    .rd_en_i(rd_en), .rd_entry_o(rd_entry)
  );

  rx_fifo_level #(.DEPTH(DEPTH)) u_level (
    .clk_i, .rst_ni,
    .inc_i(wr_en), .dec_i(rd_en), .trig_sel_i,
    .level_o, .empty_o(empty), .full_o(full), .irq_o
  );

  rx_fifo_ovr u_ovr (
    .clk_i, .rst_ni,
    .set_i(ovr_set), .clr_i(ovr_clr_i), .flag_o(overrun_o)
  );

  assign rd_data_o       = rd_entry.data;
  assign rd_frame_err_o  = rd_entry.frm;
  assign rd_parity_err_o = rd_entry.par;
  assign rd_break_o      = rd_entry.brk;
  assign data_avail_o    = !empty;
endmodule

// File: rtl/rx_char_fifo_chk.sv
module rx_char_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          ovr_clr_i,
  input logic [CW-1:0] level_o,
  input logic          data_avail_o,
  input logic          irq_o,
  input logic          overrun_o
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  a_r4_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_avail_o == (level_o != '0));

  a_r5_push_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && level_o != FULL_LVL) |=> level_o == $past(level_o) + 1'b1);

  a_r5_pop_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && level_o != '0) |=> level_o == $past(level_o) - 1'b1);

  a_r5_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && level_o == '0) |=> level_o == '0);

  a_r6_irq_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> !irq_o);

  a_r7_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && level_o == FULL_LVL) |=> (overrun_o && level_o == FULL_LVL));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  a_r9_full_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && level_o == FULL_LVL && !overrun_o) |=> (!overrun_o && level_o == FULL_LVL));

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= FULL_LVL);
endmodule

bind rx_char_fifo rx_char_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .push_i, .pop_i, .ovr_clr_i,
  .level_o, .data_avail_o, .irq_o, .overrun_o
);

// File: tb/tb_rx_char_fifo.sv
`timescale 1ns/1ps
module tb_rx_char_fifo;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       push_i = 0, pop_i = 0, ovr_clr_i = 0;
  logic [7:0] push_data_i = '0;
  logic       push_frame_err_i = 0, push_parity_err_i = 0, push_break_i = 0;
  logic [1:0] trig_sel_i = '0;
  logic [7:0] rd_data_o;
  logic       rd_frame_err_o, rd_parity_err_o, rd_break_o;
  logic       data_avail_o, irq_o, overrun_o;
  logic [4:0] level_o;

  int checks = 0, failures = 0;
  logic [10:0] q[$];
  logic        m_ovr = 0;

  always #2.5 clk = ~clk;

  rx_char_fifo dut (.clk_i(clk), .*);

  function automatic int thr(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R5/R10 level", int'(level_o), q.size());
    chk("R4 data_avail", int'(data_avail_o), int'(q.size() > 0));
    chk("R6 irq", int'(irq_o), int'(q.size() >= thr(trig_sel_i)));
    chk("R7/R8 overrun", int'(overrun_o), int'(m_ovr));
    if (q.size() > 0) begin
      chk("R2 head byte", int'(rd_data_o), int'(q[0][7:0]));
      chk("R3 head flags", int'({rd_break_o, rd_parity_err_o, rd_frame_err_o}), int'(q[0][10:8]));
    end
  endtask

  // drive one cycle at negedge, update model, check after edge
  task automatic step(input logic ps, input logic [10:0] e, input logic pp, input logic clr);
    bit full, popok;
    @(negedge clk);
    push_i = ps; pop_i = pp; ovr_clr_i = clr;
    {push_break_i, push_parity_err_i, push_frame_err_i, push_data_i} = e;
    full  = (q.size() == 16);
    popok = pp && q.size() > 0;
    @(posedge clk); #1;
    if (popok) void'(q.pop_front());
    if (ps && (!full || popok)) q.push_back(e);
    if (ps && full && !popok) m_ovr = 1;
    else if (clr) m_ovr = 0;
    push_i = 0; pop_i = 0; ovr_clr_i = 0;
    check_all();
  endtask

  initial begin
    logic [10:0] head_before;
    void'($urandom(32'h5eed_1234));
    #12 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(level_o), 0);
    chk("R1 data_avail", int'(data_avail_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 overrun", int'(overrun_o), 0);
    // R5 pop on empty ignored
    step(0, '0, 1, 0);
    // fill to 16 with threshold scan (R6)
    for (int i = 0; i < 16; i++) begin
      trig_sel_i = 2'(i % 4);
      step(1, 11'(i * 37 + 11'h500), 0, 0);
    end
    // R7 overrun: discard, contents kept
    head_before = q[0];
    step(1, 11'h0ff, 0, 0);
    chk("R7 head kept", int'({rd_break_o, rd_parity_err_o, rd_frame_err_o, rd_data_o}), int'(head_before));
    chk("R7 overrun flag", int'(overrun_o), 1);
    // R8 sticky across idle, clear
    step(0, '0, 0, 0);
    step(0, '0, 0, 1);
    chk("R8 cleared", int'(overrun_o), 0);
    // R9 full push+pop
    step(1, 11'h3a5, 1, 0);
    chk("R9 no overrun", int'(overrun_o), 0);
    // R8 set wins over clear
    step(1, 11'h111, 0, 1);
    chk("R8 set beats clear", int'(overrun_o), 1);
    step(0, '0, 0, 1);
    // R6 irq drop while draining at threshold 14
    trig_sel_i = 2'd3;
    for (int i = 0; i < 16; i++) step(0, '0, 1, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int bias = (n / 500) % 2 ? 70 : 30;
      trig_sel_i = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 99) < bias), 11'($urandom), ($urandom_range(0, 99) < 100 - bias),
           ($urandom_range(0, 19) == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule